// File: doc/BRIEF.md
# Machine-Cycle Clock Divider with Switchback

This block derives the machine-cycle timing of a small processor core from its oscillator clock. It emits a strobe that is high for one oscillator clock at the end of every machine cycle. A machine cycle lasts 4 oscillator clocks at full speed. Software may select 64 or 1024 clocks per cycle instead, which saves power because everything clocked by the strobe slows down with it.

A switchback circuit ends a slow period without any software action. While switchback is enabled, a pending interrupt or activity on the serial port sets the selected rate back to the fast divide. Serial activity means a start-bit falling edge on the receive line or a write pulse to the transmit buffer. A change of rate, from software or from switchback, is applied only when the running machine cycle ends, so no cycle is ever cut short. No data moves through the block, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `mcyc_divider`

## Requirements
- R1: After reset the rate code reads 0 (fast), the phase count is 0, and the first strobe appears on the fourth clock after reset is released.
- R2: Rate codes are 0 = 4, 1 = 64 and 2 = 1024 oscillator clocks per machine cycle. A write pulse with one of these codes updates the readback on the next clock.
- R3: A write of code 3 is ignored, and the readback keeps its previous code.
- R4: The strobe is high for exactly one clock per machine cycle, and strobes are spaced by the divide of the active rate.
- R5: The phase count is 0 on the clock after a strobe and rises by one on each clock up to the strobe.
- R6: A new rate takes effect only at the next machine-cycle boundary. The cycle in progress finishes at its old length.
- R7: With switchback enabled, a pending interrupt sets the readback to 0 on the next clock. The fast rate starts after the current cycle ends.
- R8: With switchback enabled, a falling edge on the receive line sets the readback to 0 three clocks after the edge (two synchronizer stages plus the mode register). A rising edge has no effect.
- R9: With switchback enabled, a transmit-write pulse sets the readback to 0 on the next clock.
- R10: With switchback disabled, interrupt and serial events leave the selected rate and the strobe period unchanged.
- R11: If switchback and a software write of a slow code occur in the same clock, switchback wins and the readback is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | One-clock write pulse for the rate register |
| mode_wdata | input | 2 | Rate code to write |
| swb_en | input | 1 | Enables hardware switchback |
| irq_pend | input | 1 | An interrupt request is pending |
| ser_rx | input | 1 | Asynchronous serial receive line, idle high |
| ser_tx_wr | input | 1 | Pulse marking a write to the transmit buffer |
| cyc_stb | output | 1 | Machine-cycle strobe, one clock wide |
| phase | output | 10 | Oscillator-clock position within the machine cycle |
| mode_rd | output | 2 | Currently selected rate code |

## Verification
The readback changes one clock after a write, an interrupt or a transmit pulse, and three clocks after a receive-line falling edge. The bench drives on the falling clock edge and samples the readback exactly that many falling edges later. Strobe timing is due one full divide after the previous strobe, so the bench counts falling edges from one strobe to the next. When a change lands mid-cycle, the bench counts from the last strobe before the change, which proves the old length was kept. The phase count is checked on the sample just after each strobe, where it must be 0.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;

  // code 3 is reserved and never accepted
  function automatic logic rate_code_ok(input logic [1:0] code);
    return code != 2'd3;
  endfunction

endpackage

// File: rtl/mcyc_serial_detect.sv
module mcyc_serial_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_rx,
  input  logic ser_tx_wr,
  output logic ser_evt
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] rx_chain;
  logic             rx_fall;

  // synchronizer plus one history stage, idle level is high
  for (genvar g = 0; g < CHAIN; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) rx_chain[g] <= 1'b1;
        else        rx_chain[g] <= ser_rx;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) rx_chain[g] <= 1'b1;
        else        rx_chain[g] <= rx_chain[g-1];
      end
    end
  end

  assign rx_fall = rx_chain[CHAIN-1] & ~rx_chain[CHAIN-2];
  assign ser_evt = rx_fall | ser_tx_wr;

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall |=> !rx_fall);

endmodule

// File: rtl/mcyc_mode_ctrl.sv
module mcyc_mode_ctrl
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       swb_en,
  input  logic       irq_pend,
  input  logic       ser_evt,
  output rate_e      sel_rate
);

  logic  swb_hit;
  logic  wr_ok;
  rate_e sel_q;

  assign swb_hit = swb_en & (irq_pend | ser_evt);
  assign wr_ok   = mode_wr & rate_code_ok(mode_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= RATE_FAST;
    else if (swb_hit) sel_q <= RATE_FAST;
    else if (wr_ok)   sel_q <= rate_e'(mode_wdata);
  end

  assign sel_rate = sel_q;

  // R7
  irq_swb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_en && irq_pend) |=> (sel_rate == RATE_FAST));

  // R10
  swb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!swb_en && !mode_wr) |=> $stable(sel_rate));

  // R3
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata == 2'd3 && !swb_en) |=> $stable(sel_rate));

endmodule

// File: rtl/mcyc_phase_counter.sv
module mcyc_phase_counter
  import mcyc_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int MID_DIV  = 64,
  parameter int SLOW_DIV = 1024,
  parameter int CNT_W    = $clog2(SLOW_DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rate_e            sel_rate,
  output logic             cyc_stb,
  output logic [CNT_W-1:0] phase
);

  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(MID_DIV - 1);
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(SLOW_DIV - 1);

  rate_e            act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    unique case (act_q)
      RATE_MID:  lim = LIM_MID;
      RATE_SLOW: lim = LIM_SLOW;
      default:   lim = LIM_FAST;
    endcase
  end

  assign cyc_stb = (cnt_q == lim);
  assign phase   = cnt_q;

  // the active rate is loaded only at a cycle boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= RATE_FAST;
    end else if (cyc_stb) begin
      cnt_q <= '0;
      act_q <= sel_rate;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |=> !cyc_stb);

  // R5
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_stb |=> (phase == '0));

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> (phase == $past(phase) + 1'b1));

  // R6
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb |=> $stable(act_q));

endmodule

// File: rtl/mcyc_divider.sv
module mcyc_divider
  import mcyc_pkg::*;
#(
  parameter int FAST_DIV    = 4,
  parameter int MID_DIV     = 64,
  parameter int SLOW_DIV    = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(SLOW_DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             swb_en,
  input  logic             irq_pend,
  input  logic             ser_rx,
  input  logic             ser_tx_wr,
  output logic             cyc_stb,
  output logic [CNT_W-1:0] phase,
  output logic [1:0]       mode_rd
);

  logic  ser_evt;
  rate_e sel_rate;

  mcyc_serial_detect #(.SYNC_STAGES(SYNC_STAGES)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_rx    (ser_rx),
    .ser_tx_wr (ser_tx_wr),
    .ser_evt   (ser_evt)
  );

  mcyc_mode_ctrl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .swb_en     (swb_en),
    .irq_pend   (irq_pend),
    .ser_evt    (ser_evt),
    .sel_rate   (sel_rate)
  );

  mcyc_phase_counter #(
    .FAST_DIV (FAST_DIV),
    .MID_DIV  (MID_DIV),
    .SLOW_DIV (SLOW_DIV),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_rate (sel_rate),
    .cyc_stb  (cyc_stb),
    .phase    (phase)
  );

  assign mode_rd = sel_rate;

  // R9
  tx_swb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_en && ser_tx_wr) |=> (mode_rd == 2'd0));

  // R11
  swb_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_en && irq_pend && mode_wr) |=> (mode_rd == 2'd0));

endmodule

// File: tb/mcyc_divider_tb.sv
module mcyc_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [1:0] mode_wdata;
  logic       swb_en;
  logic       irq_pend;
  logic       ser_rx;
  logic       ser_tx_wr;
  logic       cyc_stb;
  logic [9:0] phase;
  logic [1:0] mode_rd;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mcyc_divider dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .swb_en(swb_en), .irq_pend(irq_pend), .ser_rx(ser_rx),
    .ser_tx_wr(ser_tx_wr), .cyc_stb(cyc_stb), .phase(phase), .mode_rd(mode_rd)
  );

  // {rate code, expected clocks per machine cycle}
  localparam logic [12:0] VEC [6] = '{
    {2'd1, 11'd64}, {2'd0, 11'd4}, {2'd2, 11'd1024},
    {2'd1, 11'd64}, {2'd0, 11'd4}, {2'd2, 11'd1024}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wait_stb();
    while (!cyc_stb) @(negedge clk);
  endtask

  // starts on a strobe sample, ends on the next strobe sample
  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk(!cyc_stb, "R4 strobe width", int'(cyc_stb), 0);
        chk(phase == 0, "R5 phase after strobe", int'(phase), 0);
      end
    end while (!cyc_stb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = 2'd0; swb_en = 1'b0;
    irq_pend = 1'b0; ser_rx = 1'b1; ser_tx_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and first strobe
    chk(mode_rd == 2'd0, "R1 mode after reset", int'(mode_rd), 0);
    chk(phase == 10'd1, "R1 phase counts from reset", int'(phase), 1);
    n = 1;
    while (!cyc_stb) begin @(negedge clk); n++; end
    chk(n == 3, "R1 first strobe", n, 3);

    // R2 R4 R5 table walk
    foreach (VEC[i]) begin
      set_mode(VEC[i][12:11]);
      chk(mode_rd == VEC[i][12:11], "R2 readback", int'(mode_rd), int'(VEC[i][12:11]));
      wait_stb();
      measure(n);
      chk(n == int'(VEC[i][10:0]), "R2 R4 period", n, int'(VEC[i][10:0]));
    end

    // R6 mid-cycle change keeps current length (now slow)
    n = 0;
    repeat (100) begin @(negedge clk); n++; end
    set_mode(2'd0); n++;
    while (!cyc_stb) begin @(negedge clk); n++; end
    chk(n == 1024, "R6 old cycle length kept", n, 1024);
    measure(n);
    chk(n == 4, "R6 new rate after boundary", n, 4);

    // R3 reserved code ignored
    set_mode(2'd3);
    chk(mode_rd == 2'd0, "R3 code 3 ignored", int'(mode_rd), 0);
    set_mode(2'd1);
    set_mode(2'd3);
    chk(mode_rd == 2'd1, "R3 code 3 ignored", int'(mode_rd), 1);

    // R10 switchback disabled
    irq_pend = 1'b1; ser_tx_wr = 1'b1; ser_rx = 1'b0;
    @(negedge clk);
    ser_tx_wr = 1'b0;
    repeat (5) @(negedge clk);
    irq_pend = 1'b0; ser_rx = 1'b1;
    chk(mode_rd == 2'd1, "R10 events ignored", int'(mode_rd), 1);
    repeat (4) @(negedge clk);
    wait_stb();
    measure(n);
    chk(n == 64, "R10 slow period kept", n, 64);

    // R7 interrupt switchback from slow rate
    set_mode(2'd2);
    wait_stb();
    measure(n);
    chk(n == 1024, "R7 slow before switchback", n, 1024);
    swb_en = 1'b1;
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    n = 1;
    chk(mode_rd == 2'd0, "R7 readback fast", int'(mode_rd), 0);
    while (!cyc_stb) begin @(negedge clk); n++; end
    chk(n == 1024, "R7 cycle not cut", n, 1024);
    measure(n);
    chk(n == 4, "R7 fast after switchback", n, 4);

    // R8 receive falling edge
    set_mode(2'd1);
    wait_stb();
    measure(n);
    ser_rx = 1'b0;
    repeat (2) @(negedge clk);
    chk(mode_rd == 2'd1, "R8 not before sync delay", int'(mode_rd), 1);
    @(negedge clk);
    chk(mode_rd == 2'd0, "R8 falling edge switchback", int'(mode_rd), 0);
    wait_stb();
    measure(n);
    chk(n == 4, "R8 fast after rx edge", n, 4);
    set_mode(2'd1);
    ser_rx = 1'b1;
    repeat (5) @(negedge clk);
    chk(mode_rd == 2'd1, "R8 rising edge ignored", int'(mode_rd), 1);

    // R9 transmit write
    ser_tx_wr = 1'b1;
    @(negedge clk);
    ser_tx_wr = 1'b0;
    chk(mode_rd == 2'd0, "R9 tx write switchback", int'(mode_rd), 0);

    // R11 switchback beats software write
    irq_pend = 1'b1;
    set_mode(2'd2);
    irq_pend = 1'b0;
    chk(mode_rd == 2'd0, "R11 switchback wins", int'(mode_rd), 0);
    set_mode(2'd2);
    chk(mode_rd == 2'd2, "R11 write after event", int'(mode_rd), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule